// File: doc/BRIEF.md
# DRAM Write Cycle Type Classifier

This block watches the row strobe, the column strobe and the write-enable strobe of an asynchronous DRAM interface during one access, with the row strobe held low. It sorts the access into one of four kinds: a read, an early write, a read-modify-write or an indeterminate cycle. The strobes are sampled on a system clock. The kind is decided from how the sampled edges are spaced, counted in clock cycles, against four minimums that arrive on configuration inputs.

The decision controls two things. The first is the data-out enable, which forwards the array's read data. The second is the point at which the data-in bus is latched into a write. An early write keeps data out quiet. A read-modify-write forwards the read data for the whole access. An indeterminate cycle turns data out off and raises an error flag, so no unknown value is ever driven. The result is published when the row strobe rises and stays valid until the row strobe falls again.

Top module: `dram_wcycle_mon`

## Requirements
- R1: After reset, `dout_oe`, `wr_stb`, `ctype_vld` and `err` are 0, and `dout` is 0.
- R2: Let W be the cycle in which WE is first sampled low during the access and C the cycle in which CAS is first sampled falling, with W <= C. If C - W >= `cfg_wcs`, the access is an early write (type code 2'b01) and `dout_oe` stays 0 for the whole access.
- R3: Let W > C. If W >= `cfg_rwd` (counted from the RAS-fall sample, which is cycle 0), W - C >= `cfg_cwd`, and the column strobe was first seen in cycle K <= W with W - K >= `cfg_awd`, the access is a read-modify-write (code 2'b10). `dout_oe` is 1 from the sample after C until RAS rises.
- R4: If WE falls but neither R2 nor R3 holds, the access is indeterminate (code 2'b11). From the sample after max(C, W), `dout_oe` is 0 and `err` is 1. `err` stays 1 until the next RAS fall.
- R5: If WE never falls, the access is a read (code 2'b00). `dout_oe` is 1 from the sample after C until RAS rises, and `dout_oe` is always 0 while RAS is high.
- R6: Whenever WE falls during an access, `wr_stb` pulses high for exactly one cycle after the sample max(C, W). `wr_data` then holds the value `din` had at that sample. So an early write latches at the CAS edge, and a delayed write or read-modify-write latches at the WE edge.
- R7: `ctype` takes the type code in the sample after RAS rises, with `ctype_vld` = 1. `ctype_vld` is 0 from the sample after RAS falls.
- R8: `dout` equals `rd_data` whenever `dout_oe` is 1, and is 0 otherwise.
- R9: Each minimum is met at equality. With all four minimums at 0, WE at or before CAS gives an early write, and WE after CAS (with the column strobe seen first) gives a read-modify-write.
- R10: A column strobe seen only after the WE fall fails the R3 test, so the access is indeterminate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_stb | input | 1 | Pulse marking the column address as valid |
| cfg_wcs | input | CW | Minimum WE-to-CAS lead for an early write |
| cfg_rwd | input | CW | Minimum RAS-fall-to-WE delay for read-modify-write |
| cfg_cwd | input | CW | Minimum CAS-fall-to-WE delay for read-modify-write |
| cfg_awd | input | CW | Minimum column-strobe-to-WE delay for read-modify-write |
| din | input | DW | Write data from the bus |
| rd_data | input | DW | Read data from the array |
| dout | output | DW | Data out, gated by the enable |
| dout_oe | output | 1 | Data-out enable |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | DW | Latched write data |
| ctype | output | 2 | Cycle type code |
| ctype_vld | output | 1 | Cycle type valid |
| err | output | 1 | Indeterminate cycle flag |

## Verification
The bench sweeps every CAS, WE and column-strobe placement inside a short access, under three sets of minimums. One of those sets is all zeros, and another puts the spacings exactly on their limits. This targets the off-by-one boundary: a design that compares with > instead of >= would classify an on-limit early write or read-modify-write as indeterminate. It also targets the case where WE and CAS fall in the same sample. Here, a design that treated that sample as a delayed write would latch the data at the wrong moment or drive data out during a write. The sweep also includes a column strobe that arrives late, which a design that skipped the column-to-WE check would accept as a read-modify-write. Finally, it checks that `err` and the type code survive across the RAS-high gap and clear only at the next RAS fall.

// File: rtl/dram_wcycle_mon.sv
module dram_wcycle_mon #(
  parameter int DW = 4,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          col_stb,
  input  logic [CW-1:0] cfg_wcs,
  input  logic [CW-1:0] cfg_rwd,
  input  logic [CW-1:0] cfg_cwd,
  input  logic [CW-1:0] cfg_awd,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic [1:0]    ctype,
  output logic          ctype_vld,
  output logic          err
);
  localparam logic [1:0] T_RD = 2'b00, T_EW = 2'b01, T_RMW = 2'b10, T_IND = 2'b11;
  localparam logic [CW-1:0] TMAX = '1;

  logic          prev_ras, prev_cas, prev_we;
  logic          cas_seen, we_seen, col_seen;
  logic [CW-1:0] tick, t_cas, t_we, t_col;
  logic [1:0]    cls;

  logic          ras_fall, ras_rise, cs, ws, ks;
  logic          cas_fall, we_fall, col_ev;
  logic [CW-1:0] cur, tw, tk;
  logic          ew_ok, rmw_ok, dec_ew, dec_rd, dec_dw, dec;
  logic [1:0]    nxt_cls;

  assign ras_fall = prev_ras & ~ras_n;
  assign ras_rise = ~prev_ras & ras_n;
  assign cur      = ras_fall ? '0 : tick;
  assign cs       = cas_seen & ~ras_fall;
  assign ws       = we_seen & ~ras_fall;
  assign ks       = col_seen & ~ras_fall;

  assign cas_fall = ~ras_n & prev_cas & ~cas_n & ~cs;
  assign we_fall  = ~ras_n & ~we_n & ~ws & (prev_we | ras_fall);
  assign col_ev   = ~ras_n & col_stb & ~ks;

  assign tw = ws ? t_we : cur;
  assign tk = ks ? t_col : cur;

  assign ew_ok  = (cur - tw) >= cfg_wcs;
  assign rmw_ok = (cur >= cfg_rwd) && ((cur - t_cas) >= cfg_cwd) &&
                  (ks | col_ev) && ((cur - tk) >= cfg_awd);

  assign dec_ew  = cas_fall & (ws | we_fall);
  assign dec_rd  = cas_fall & ~(ws | we_fall);
  assign dec_dw  = we_fall & cs;
  assign dec     = dec_ew | dec_dw;
  assign nxt_cls = dec_ew ? (ew_ok ? T_EW : T_IND) : (rmw_ok ? T_RMW : T_IND);

  assign dout = dout_oe ? rd_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ras  <= 1'b1;
      prev_cas  <= 1'b1;
      prev_we   <= 1'b1;
      cas_seen  <= 1'b0;
      we_seen   <= 1'b0;
      col_seen  <= 1'b0;
      tick      <= '0;
      t_cas     <= '0;
      t_we      <= '0;
      t_col     <= '0;
      cls       <= T_RD;
      dout_oe   <= 1'b0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
      ctype     <= T_RD;
      ctype_vld <= 1'b0;
      err       <= 1'b0;
    end else begin
      prev_ras <= ras_n;
      prev_cas <= cas_n;
      prev_we  <= we_n;
      cas_seen <= ~ras_n & (cs | cas_fall);
      we_seen  <= ~ras_n & (ws | we_fall);
      col_seen <= ~ras_n & (ks | col_ev);
      tick     <= ras_n ? '0 : ((cur == TMAX) ? cur : cur + 1'b1);
      if (cas_fall) t_cas <= cur;
      if (we_fall)  t_we  <= cur;
      if (col_ev)   t_col <= cur;

      if (dec)           cls <= nxt_cls;
      else if (ras_fall) cls <= T_RD;

      if (ras_n)                          dout_oe <= 1'b0;
      else if (dec_rd)                    dout_oe <= 1'b1;
      else if (dec && nxt_cls != T_RMW)   dout_oe <= 1'b0;

      if (dec && nxt_cls == T_IND) err <= 1'b1;
      else if (ras_fall)           err <= 1'b0;

      wr_stb <= dec;
      if (dec) wr_data <= din;

      if (ras_rise) begin
        ctype     <= cls;
        ctype_vld <= 1'b1;
      end else if (ras_fall) begin
        ctype_vld <= 1'b0;
      end
    end
  end
endmodule

module dram_wcycle_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       dout_oe,
  input logic       wr_stb,
  input logic       ctype_vld,
  input logic       err,
  input logic [1:0] cls
);
  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_oe_ras_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n) |-> !dout_oe);
  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !dout_oe);
  assert_ew_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == 2'b01) |-> !dout_oe);
  assert_vld_ras_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ras_n) |-> !ctype_vld);
endmodule

bind dram_wcycle_mon dram_wcycle_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .dout_oe(dout_oe),
  .wr_stb(wr_stb), .ctype_vld(ctype_vld), .err(err), .cls(cls)
);

// File: tb/dram_wcycle_mon_tb.sv
module dram_wcycle_mon_tb;
  localparam int DW = 4;
  localparam int CW = 6;
  localparam int RLEN = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, col_stb = 1'b0;
  logic [CW-1:0] cfg_wcs = '0, cfg_rwd = '0, cfg_cwd = '0, cfg_awd = '0;
  logic [DW-1:0] din = '0, rd_data = '0;
  logic [DW-1:0] dout, wr_data;
  logic          dout_oe, wr_stb, ctype_vld, err;
  logic [1:0]    ctype;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_wcycle_mon #(.DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .col_stb(col_stb), .cfg_wcs(cfg_wcs), .cfg_rwd(cfg_rwd), .cfg_cwd(cfg_cwd),
    .cfg_awd(cfg_awd), .din(din), .rd_data(rd_data), .dout(dout),
    .dout_oe(dout_oe), .wr_stb(wr_stb), .wr_data(wr_data), .ctype(ctype),
    .ctype_vld(ctype_vld), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int classify(int tc, int tw, int tk, int wcs, int rwd, int cwd, int awd);
    if (tw < 0) return 0;
    if (tw <= tc) return ((tc - tw) >= wcs) ? 1 : 3;
    if (tw >= rwd && (tw - tc) >= cwd && tk <= tw && (tw - tk) >= awd) return 2;
    return 3;
  endfunction

  task automatic run_access(input int tc, input int tw, input int tk, input int seed);
    int cls;
    int d;
    cls = classify(tc, tw, tk, int'(cfg_wcs), int'(cfg_rwd), int'(cfg_cwd), int'(cfg_awd));
    d = (tw > tc) ? tw : tc;
    for (int i = 0; i < RLEN; i++) begin
      @(negedge clk);
      ras_n   = 1'b0;
      cas_n   = !(i >= tc);
      we_n    = !(tw >= 0 && i >= tw);
      col_stb = (i == tk);
      din     = DW'(i * 3 + seed);
      rd_data = DW'(seed * 5 + 1);
      @(posedge clk);
      #1;
      begin
        bit eoe;
        eoe = (i >= tc) && !(tw >= 0 && tw <= tc) && !(cls == 3 && i >= tw);
        if (cls == 1) chk("R2 oe early write", int'(dout_oe), 0);
        else if (cls == 2) chk("R3 oe rmw", int'(dout_oe), int'(eoe));
        else if (cls == 0) chk("R5 oe read", int'(dout_oe), int'(eoe));
        else chk("R4 oe indeterminate", int'(dout_oe), int'(eoe));
        chk("R8 dout", int'(dout), eoe ? int'(rd_data) : 0);
        chk("R4 err", int'(err), int'(cls == 3 && i >= d));
        chk("R6 wr_stb", int'(wr_stb), int'(tw >= 0 && i == d));
        if (tw >= 0 && i == d) chk("R6 wr_data", int'(wr_data), (d * 3 + seed) % 16);
        if (i == 0) chk("R7 vld low", int'(ctype_vld), 0);
      end
    end
    @(negedge clk);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; col_stb = 1'b0;
    @(posedge clk);
    #1;
    if (tk > tw && tw > tc) chk("R10 late column", int'(ctype), cls);
    else if (cfg_wcs == 0 && cfg_rwd == 0) chk("R9 zero minimums", int'(ctype), cls);
    else chk("R7 ctype", int'(ctype), cls);
    chk("R7 vld", int'(ctype_vld), 1);
    chk("R5 oe ras high", int'(dout_oe), 0);
    chk("R4 err held", int'(err), int'(cls == 3));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 oe", int'(dout_oe), 0);
    chk("R1 wr_stb", int'(wr_stb), 0);
    chk("R1 vld", int'(ctype_vld), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 dout", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      case (c)
        0: begin cfg_wcs = 2; cfg_rwd = 4; cfg_cwd = 2; cfg_awd = 1; end
        1: begin cfg_wcs = 0; cfg_rwd = 0; cfg_cwd = 0; cfg_awd = 0; end
        default: begin cfg_wcs = 1; cfg_rwd = 6; cfg_cwd = 3; cfg_awd = 3; end
      endcase
      for (int tc = 1; tc <= 3; tc++)
        for (int tw = -1; tw <= 7; tw++)
          for (int kk = 0; kk < 2; kk++)
            run_access(tc, tw, (kk == 0) ? 0 : 5, c * 50 + tc * 9 + tw + kk);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule